// File: doc/BRIEF.md
# Block-Protocol Register Target for a Two-Wire Management Bus

This block is a target on a two-wire management bus and never starts a transfer itself. It gives a bus host access to a small internal file of 8-bit registers, and it uses only two transfer forms. To store data, the host sends a write that carries a command byte and a byte count. To fetch data, the host sends a read that returns a byte count first. The command byte picks the first register to access. The register pointer then steps by one after each data byte, in both directions, and wraps from the last register back to register 0. Bytes travel most significant bit first.

The target samples SCL and SDA through synchronising flip-flops on the system clock. It detects START when SDA falls while SCL is high, and STOP when SDA rises while SCL is high. It answers only its own 7-bit address. It pulls SDA low through an open-drain style output to acknowledge a byte and to send the zero bits of read data. All other transfer forms receive a fixed response: the target sends no acknowledge, or it stores nothing.

The block also drives a sticky output named `load_done`. Until the host has set this output by writing the last register, the surrounding logic holds its downstream operation, for as long as that takes.

Top module: `smb_blk_slave`

## Requirements
- R1: While reset is applied and after it is released, `sda_pull` is low (SDA released) and `load_done` is low.
- R2: The target acknowledges only an address byte whose upper seven bits equal `DEV_ADDR`. For any other address it leaves the acknowledge bit high, and it then acknowledges nothing and stores nothing until the next START.
- R3: A block write consists of the address with bit 0 = 0, a command byte C < `NREGS`, a count byte N, and then N data bytes. The target acknowledges each of these bytes and stores data byte i in register (C+i) mod `NREGS`. Data is received MSB first.
- R4: Data bytes that arrive after N bytes have already been stored are not acknowledged and are not stored. A count of 0 means that no data byte is stored.
- R5: A transfer that ends before a full count byte and its data bytes, for example address + command + STOP, or address + command + one byte + STOP, leaves every register unchanged.
- R6: A block read consists of the address with bit 0 = 0, a command byte C, a repeated START, and the address with bit 0 = 1. The target then sends the count `NREGS`-C, followed by registers C, C+1, and so on, MSB first. It continues while the host acknowledges and stops sending after the host leaves the acknowledge bit high.
- R7: An address with bit 0 = 1 is not acknowledged unless an accepted command byte came earlier in the same transfer, with no STOP between the two.
- R8: A command byte of `NREGS` or more is not acknowledged, and the rest of that transfer stores nothing.
- R9: `load_done` rises after a data byte with bit 0 = 1 is stored into register `NREGS`-1. It stays high until reset. Writing a byte with bit 0 = 0 to that register does not set it and does not clear it.
- R10: `sda_pull` changes only while SCL is low, so the target never alters SDA during the high phase of a clock.
- R11: A STOP ends any transfer and releases SDA. A START in the middle of a transfer restarts the address phase, and data bytes already stored stay stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as sensed at the pin |
| sda_in | input | 1 | Bus data line as sensed at the pin (wired-AND of all drivers) |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release it |
| load_done | output | 1 | Sticky flag showing that the host has completed the configuration load |

## Verification
The hardest cases to reach are the boundaries of a transfer that sit inside a running byte stream. Examples are the byte that comes one position after the declared count, a count byte followed directly by STOP, and a read address that arrives after a STOP has cleared the stored command. The bench reaches each of these with a bit-level bus master model. This model can send any byte sequence, and it can place START, repeated START and STOP at any byte boundary. After each such transfer, a block read shows through the normal bus interface whether any register changed. Sweeps over every command start position and every 7-bit address cover the pointer wrap and the address match against a register model that the bench keeps.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_CNT,
    ST_WDATA,
    ST_TCNT,
    ST_TDATA
  } smb_state_t;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic scl_p,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_sh;
  logic [STAGES-1:0] sda_sh;
  logic              sda_p;

  // Metastability chains; the bus idles high, so reset to ones.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_sh[STAGES-1];
      sda_p  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  // Single write port, registered read: maps onto a block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/smb_proto.sv
module smb_proto
  import smb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  parameter int         NREGS    = 16,
  parameter int         AW       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          sda_low,
  output logic          done_flag
);

  localparam logic [7:0]    NREGS8   = 8'(NREGS);
  localparam logic [AW-1:0] LAST_IDX = AW'(NREGS - 1);

  smb_state_t    st, nxt_st;
  logic [7:0]    sreg;
  logic [7:0]    txbyte;
  logic [7:0]    wr_left;
  logic [3:0]    bitcnt;
  logic          ack_slot;
  logic          m_ack;
  logic          have_cmd;
  logic [AW-1:0] ptr;
  logic          rx_phase;
  logic          tx_phase;
  logic [2:0]    tx_idx;
  logic [7:0]    ptr8;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign rx_phase = (st == ST_ADDR) || (st == ST_CMD) || (st == ST_CNT) || (st == ST_WDATA);
  assign tx_phase = (st == ST_TCNT) || (st == ST_TDATA);
  assign tx_idx   = 3'd7 - bitcnt[2:0];
  assign ptr8     = 8'(ptr);
  assign rd_addr  = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      nxt_st   <= ST_IDLE;
      sreg     <= '0;
      txbyte   <= '0;
      wr_left  <= '0;
      bitcnt   <= '0;
      ack_slot <= 1'b0;
      m_ack    <= 1'b0;
      have_cmd <= 1'b0;
      ptr      <= '0;
      sda_low  <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st       <= ST_ADDR;
        bitcnt   <= '0;
        ack_slot <= 1'b0;
        sda_low  <= 1'b0;
      end else if (stop_det) begin
        st       <= ST_IDLE;
        bitcnt   <= '0;
        ack_slot <= 1'b0;
        sda_low  <= 1'b0;
        have_cmd <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          if (ack_slot) begin
            m_ack <= ~sda_s;
          end else if (bitcnt < 4'd8) begin
            bitcnt <= bitcnt + 4'd1;
            if (rx_phase) sreg <= {sreg[6:0], sda_s};
          end
        end else if (scl_fall) begin
          if (ack_slot) begin
            // End of the acknowledge clock: move to the next byte.
            ack_slot <= 1'b0;
            bitcnt   <= '0;
            if (tx_phase) begin
              if (m_ack) begin
                st      <= ST_TDATA;
                txbyte  <= rd_data;
                ptr     <= step(ptr);
                sda_low <= ~rd_data[7];
              end else begin
                st      <= ST_IDLE;
                sda_low <= 1'b0;
              end
            end else begin
              st      <= nxt_st;
              sda_low <= (nxt_st == ST_TCNT) ? ~txbyte[7] : 1'b0;
            end
          end else if (bitcnt == 4'd8) begin
            // Start of the acknowledge clock.
            ack_slot <= 1'b1;
            sda_low  <= 1'b0;
            nxt_st   <= ST_IDLE;
            if (rx_phase) begin
              case (st)
                ST_ADDR: begin
                  if (sreg[7:1] == DEV_ADDR && (!sreg[0] || have_cmd)) begin
                    sda_low <= 1'b1;
                    if (sreg[0]) begin
                      nxt_st   <= ST_TCNT;
                      txbyte   <= NREGS8 - ptr8;
                      have_cmd <= 1'b0;
                    end else begin
                      nxt_st <= ST_CMD;
                    end
                  end
                end
                ST_CMD: begin
                  if (sreg < NREGS8) begin
                    sda_low  <= 1'b1;
                    ptr      <= sreg[AW-1:0];
                    have_cmd <= 1'b1;
                    nxt_st   <= ST_CNT;
                  end
                end
                ST_CNT: begin
                  sda_low <= 1'b1;
                  wr_left <= sreg;
                  nxt_st  <= ST_WDATA;
                end
                ST_WDATA: begin
                  if (wr_left != 8'd0) begin
                    sda_low <= 1'b1;
                    wr_en   <= 1'b1;
                    wr_addr <= ptr;
                    wr_data <= sreg;
                    ptr     <= step(ptr);
                    wr_left <= wr_left - 8'd1;
                    nxt_st  <= ST_WDATA;
                  end
                end
                default: ;
              endcase
            end
          end else if (tx_phase) begin
            sda_low <= ~txbyte[tx_idx];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) done_flag <= 1'b0;
    else if (wr_en && wr_addr == LAST_IDX && wr_data[0]) done_flag <= 1'b1;
  end

endmodule

// File: rtl/smb_blk_slave.sv
module smb_blk_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h2C,
  parameter int         NREGS       = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_pull,
  output logic load_done
);

  localparam int AW = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic          scl_s, scl_p, sda_s;
  logic          scl_rise, scl_fall, start_det, stop_det;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0]    rd_data, wr_data;
  logic          wr_en;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_in),
    .sda_i    (sda_in),
    .scl_s    (scl_s),
    .scl_p    (scl_p),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  smb_regfile #(.DEPTH(NREGS), .AW(AW)) u_regs (
    .clk  (clk),
    .we   (wr_en),
    .waddr(wr_addr),
    .wdata(wr_data),
    .raddr(rd_addr),
    .rdata(rd_data)
  );

  smb_proto #(.DEV_ADDR(DEV_ADDR), .NREGS(NREGS), .AW(AW)) u_proto (
    .clk      (clk),
    .rst      (rst),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sda_low  (sda_pull),
    .done_flag(load_done)
  );

endmodule

// File: rtl/smb_blk_slave_chk.sv
module smb_blk_slave_chk (
  input logic clk,
  input logic rst,
  input logic scl_s,
  input logic scl_p,
  input logic start_det,
  input logic stop_det,
  input logic sda_pull,
  input logic load_done
);

  a_r1_reset_release: assert property (@(posedge clk)
    rst |=> (!sda_pull && !load_done));

  a_r10_sda_still_in_high: assert property (@(posedge clk) disable iff (rst)
    (scl_s && scl_p && !$past(start_det) && !$past(stop_det) && !$past(rst))
      |-> $stable(sda_pull));

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
    load_done |=> load_done);

  a_r11_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_pull);

  a_r11_start_releases: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_pull);

endmodule

bind smb_blk_slave smb_blk_slave_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_s    (scl_s),
  .scl_p    (scl_p),
  .start_det(start_det),
  .stop_det (stop_det),
  .sda_pull (sda_pull),
  .load_done(load_done)
);

// File: tb/test_smb_blk_slave.sv
`timescale 1ns/1ps
module test_smb_blk_slave;

  localparam logic [6:0] DEV = 7'h2C;
  localparam int         NR  = 16;
  localparam int         Q   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull, load_done;
  wire  sda_line = sda_m & ~sda_pull;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [7:0] model [NR];

  always #4 clk = ~clk;

  smb_blk_slave #(.DEV_ADDR(DEV), .NREGS(NR), .SYNC_STAGES(2)) i_smb_blk_slave (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull(sda_pull), .load_done(load_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic b_start();
    sda_m = 1'b1; scl_m = 1'b1; w(Q);
    sda_m = 1'b0; w(Q);
    scl_m = 1'b0;
  endtask

  task automatic b_rstart();
    w(Q); sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
    sda_m = 1'b0; w(Q); scl_m = 1'b0;
  endtask

  task automatic b_stop();
    w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q);
    sda_m = 1'b1; w(2*Q);
  endtask

  // One clock pulse; returns the line value, checks R10 (no change while high).
  task automatic b_clk(output logic v);
    logic s2;
    w(Q); scl_m = 1'b1; w(Q);
    v = sda_line; w(Q);
    s2 = sda_line;
    if (v !== s2) chk("R10 sda moved during SCL high", s2, v);
    scl_m = 1'b0;
  endtask

  task automatic b_wr(input logic [7:0] b, output logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      w(Q); sda_m = b[i];
      b_clk(v);
    end
    w(1); sda_m = 1'b1;
    b_clk(v);
    ack = ~v;
  endtask

  task automatic b_rd(input logic give_ack, output logic [7:0] b);
    logic v;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      b_clk(v);
      b[i] = v;
    end
    w(Q); sda_m = ~give_ack;
    b_clk(v);
    w(1); sda_m = 1'b1;
  endtask

  // Block write: count cnt, nsend bytes of d0, d0+step, ...
  task automatic blk_wr(input string tag, input logic [7:0] cmd, input logic [7:0] cnt,
                        input int nsend, input logic [7:0] d0, input logic [7:0] dstep);
    logic a;
    logic [7:0] d;
    b_start();
    b_wr({DEV, 1'b0}, a); chk({tag, " addr ack"}, a, 1'b1);
    b_wr(cmd, a);         chk({tag, " cmd ack"}, a, 1'b1);
    b_wr(cnt, a);         chk({tag, " count ack"}, a, 1'b1);
    for (int i = 0; i < nsend; i++) begin
      d = d0 + 8'(i) * dstep;
      b_wr(d, a);
      chk({tag, " data ack"}, a, (i < int'(cnt)) ? 1'b1 : 1'b0);
      if (i < int'(cnt)) model[(int'(cmd) + i) % NR] = d;
    end
    b_stop();
  endtask

  task automatic blk_rd(input string tag, input logic [7:0] cmd, input int k);
    logic a;
    logic [7:0] b;
    b_start();
    b_wr({DEV, 1'b0}, a); chk({tag, " addr ack"}, a, 1'b1);
    b_wr(cmd, a);         chk({tag, " cmd ack"}, a, 1'b1);
    b_rstart();
    b_wr({DEV, 1'b1}, a); chk({tag, " read addr ack"}, a, 1'b1);
    b_rd(1'b1, b);        chk({tag, " count"}, b, 8'(NR - int'(cmd)));
    for (int i = 0; i < k; i++) begin
      b_rd(i != k - 1, b);
      chk({tag, " data"}, b, model[(int'(cmd) + i) % NR]);
    end
    b_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] b;
    w(10);
    chk("R1 sda_pull in reset", sda_pull, 1'b0);
    rst = 1'b0;
    w(10);
    chk("R1 sda_pull after reset", sda_pull, 1'b0);
    chk("R1 load_done after reset", load_done, 1'b0);

    // R3 fill all registers (even values keep load_done clear), R6 full read
    blk_wr("R3 fill", 8'd0, 8'(NR), NR, 8'h36, 8'h1A);
    blk_rd("R6 full", 8'd0, NR);

    // R3/R6 sweep over every start register, including wrap of the pointer
    for (int c = 0; c < NR; c++) begin
      int n = (NR - c < 3) ? NR - c : 3;
      int k = (NR - c < 4) ? NR - c : 4;
      blk_wr("R3 sweep", 8'(c), 8'(n), n, 8'((c * 37 + 20) & 8'hFE), 8'h4A);
      blk_rd("R6 sweep", 8'(c), k);
    end
    blk_wr("R3 wrap", 8'd14, 8'd4, 4, 8'h90, 8'h06);
    blk_rd("R6 wrap", 8'd14, 4);

    // R4 bytes beyond count, and a zero count
    blk_wr("R4 over", 8'd2, 8'd2, 3, 8'h81, 8'h11);
    blk_wr("R4 zero", 8'd8, 8'd0, 1, 8'h77, 8'h00);
    blk_rd("R4 readback", 8'd2, 7);

    // R5 short transfers
    b_start(); b_wr({DEV, 1'b0}, a); b_wr(8'd9, a); b_stop();
    b_start(); b_wr({DEV, 1'b0}, a); b_wr(8'd9, a);
    b_wr(8'hE3, a); chk("R5 lone byte taken as count", a, 1'b1);
    b_stop();
    blk_rd("R5 readback", 8'd9, 1);

    // R2 address sweep; only the own address is acknowledged
    for (int ad = 0; ad < 128; ad++) begin
      b_start(); b_wr({7'(ad), 1'b0}, a); b_stop();
      chk("R2 address match", a, (7'(ad) == DEV) ? 1'b1 : 1'b0);
    end
    b_start(); b_wr({DEV ^ 7'h01, 1'b0}, a); chk("R2 foreign addr", a, 1'b0);
    b_wr(8'd3, a);  chk("R2 ignored cmd", a, 1'b0);
    b_wr(8'd1, a);  chk("R2 ignored count", a, 1'b0);
    b_wr(8'h55, a); chk("R2 ignored data", a, 1'b0);
    b_stop();
    blk_rd("R2 readback", 8'd3, 1);

    // R7 read without a preceding command
    b_start(); b_wr({DEV, 1'b1}, a); chk("R7 bare read addr", a, 1'b0); b_stop();
    b_start(); b_wr({DEV, 1'b0}, a); b_wr(8'd4, a); b_stop();
    b_start(); b_wr({DEV, 1'b1}, a); chk("R7 read after stop", a, 1'b0); b_stop();

    // R8 out-of-range commands
    b_start(); b_wr({DEV, 1'b0}, a); b_wr(8'(NR), a); chk("R8 cmd NREGS", a, 1'b0);
    b_wr(8'd1, a); chk("R8 later byte", a, 1'b0); b_stop();
    b_start(); b_wr({DEV, 1'b0}, a); b_wr(8'hFF, a); chk("R8 cmd FF", a, 1'b0); b_stop();

    // R11 STOP and repeated START in the middle of a write
    b_start(); b_wr({DEV, 1'b0}, a); b_wr(8'd5, a); b_wr(8'd3, a);
    b_wr(8'hC6, a); model[5] = 8'hC6; b_stop();
    b_start(); b_wr({DEV, 1'b0}, a); b_wr(8'd10, a); b_wr(8'd3, a);
    b_wr(8'h3C, a); model[10] = 8'h3C;
    b_rstart(); b_wr({DEV, 1'b0}, a); chk("R11 addr after repeated start", a, 1'b1);
    b_stop();
    blk_rd("R11 readback 5", 8'd5, 2);
    blk_rd("R11 readback 10", 8'd10, 2);

    // R9 completion flag
    blk_wr("R9 even", 8'(NR - 1), 8'd1, 1, 8'h02, 8'h00);
    w(20); chk("R9 even value keeps flag low", load_done, 1'b0);
    blk_wr("R9 odd", 8'(NR - 1), 8'd1, 1, 8'h03, 8'h00);
    w(20); chk("R9 flag set", load_done, 1'b1);
    blk_wr("R9 clear try", 8'(NR - 1), 8'd1, 1, 8'h00, 8'h00);
    w(20); chk("R9 flag sticky", load_done, 1'b1);
    blk_rd("R9 readback", 8'(NR - 1), 1);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule